// File: doc/BRIEF.md
# Priority-Weighted Multi-Port Arbiter

This block chooses which of up to six requester ports owns a single downstream command slot. Every port carries a priority level and a 5-bit weight. The arbiter always serves the highest priority level that currently has a pending request. Within that level, it spreads grants in proportion to the weights of the requesting ports, using a credit counter per port and a round-robin pointer per level.

A grant is registered and one-hot. It stays on the port until the downstream controller answers with `accept`. The grant then drops for one cycle, and the next decision appears after that cycle. Credits are loaded from the weights at a reload. Priority and weight inputs are captured only at reset and at each reload, so software can change them at any time without disturbing a round that is in progress.

Top module: `prio_wt_arbiter`

## Requirements
- R1: `grant` is one-hot or all zeros. It is all zeros while no port requests. A grant always goes to a port whose `req` bit was high in the cycle the decision was made.
- R2: Larger priority values win. While any port at level L is requesting, no port with a captured priority below L is granted.
- R3: Take a set of ports at one level that request continuously. Over a full credit round, each port receives exactly as many grants as its captured weight: weights 4 and 6 give 4 and 6 grants out of every 10, and weights 1 to 6 give 1 to 6 grants out of every 21.
- R4: Each port's credit is loaded from its weight at a reload, and each grant uses one credit. A reload takes one idle cycle with no grant. It happens when no requesting port at the active level has credit left and at least one of them has a nonzero weight. A lone requester with weight 1 is therefore granted once every 3 cycles while `accept` is held high.
- R5: Among the eligible ports of a level, the pick goes to the first one at a higher index than the last port granted at that level, wrapping from the top index to 0. After reset the search at every level starts at port 0.
- R6: A port with weight 0 is granted only when no requesting port at its level has a nonzero weight.
- R7: A nonzero grant holds unchanged while `accept` is low. In the cycle after `accept` is seen high, `grant` is zero, and the next grant can appear one cycle later. `accept` is ignored while `grant` is zero.
- R8: Changes to `cfg_prio` and `cfg_weight` take effect only at reset or at the next reload. The credits already loaded finish under the old weights.
- R9: A synchronous reset clears all credits and the grant. It captures the configuration and sets every level's round-robin pointer to the top port index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_PORTS | Request vector, bit i for port i |
| cfg_prio | input | NUM_PORTS*PRIO_W | Priority of port i in bits [i*PRIO_W +: PRIO_W], larger is higher |
| cfg_weight | input | NUM_PORTS*WT_W | Weight of port i in bits [i*WT_W +: WT_W], range 0 to 31 |
| accept | input | 1 | Downstream has taken the current grant |
| grant | output | NUM_PORTS | Registered one-hot grant |

## Verification
The directed patterns each separate one piece of behaviour from the others:
- Two continuously requesting ports with weights 4 and 6, and six ports with weights 1 to 6, show whether credit accounting gives exact per-round counts rather than merely favouring heavier ports.
- Three equal-weight ports on scattered indices expose the round-robin start point and the wraparound.
- A high-priority port with weight 1 against a low-priority port with weight 31 shows that priority overrides weight.
- A weight-0 port beside a weighted one shows it is served only once it is alone.
- Holding `accept` low checks that the grant stays put.
- Rewriting a weight in the middle of a round checks that the new value waits for the reload.
- The spacing between grants of a lone weight-1 port shows the idle reload cycle.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int MAX_PORTS = 6;

  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_SPEND  = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_FREE   = 2'd3
  } arb_act_e;
endpackage

// File: rtl/pwa_level_find.sv
module pwa_level_find #(
  parameter int NUM_PORTS = 6,
  parameter int PRIO_W    = 3
) (
  input  logic [NUM_PORTS-1:0]        req,
  input  logic [NUM_PORTS*PRIO_W-1:0] prio_q,
  output logic [PRIO_W-1:0]           top_lvl,
  output logic [NUM_PORTS-1:0]        at_lvl
);
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (req[i] && (prio_q[i*PRIO_W +: PRIO_W] > top_lvl)) begin
        top_lvl = prio_q[i*PRIO_W +: PRIO_W];
      end
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      at_lvl[i] = req[i] && (prio_q[i*PRIO_W +: PRIO_W] == top_lvl);
    end
  end
endmodule

// File: rtl/pwa_rr_pick.sv
module pwa_rr_pick #(
  parameter int NUM_PORTS = 6,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_PORTS-1:0] cand,
  input  logic [IDX_W-1:0]     last,
  output logic                 found,
  output logic [NUM_PORTS-1:0] pick_oh,
  output logic [IDX_W-1:0]     pick_idx
);
  always_comb begin
    found    = 1'b0;
    pick_oh  = '0;
    pick_idx = '0;
    for (int off = 1; off <= NUM_PORTS; off++) begin
      int j;
      j = (int'(last) + off) % NUM_PORTS;
      if (!found && cand[j]) begin
        found      = 1'b1;
        pick_oh[j] = 1'b1;
        pick_idx   = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/pwa_credit_bank.sv
module pwa_credit_bank #(
  parameter int NUM_PORTS = 6,
  parameter int WT_W      = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reload,
  input  logic [NUM_PORTS*WT_W-1:0] cfg_weight,
  input  logic [NUM_PORTS-1:0]      spend,
  output logic [NUM_PORTS-1:0]      has_credit,
  output logic [NUM_PORTS-1:0]      wt_nonzero
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic [WT_W-1:0] credit_q;
    logic [WT_W-1:0] wt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        credit_q <= '0;
        wt_q     <= cfg_weight[g*WT_W +: WT_W];
      end else if (reload) begin
        credit_q <= cfg_weight[g*WT_W +: WT_W];
        wt_q     <= cfg_weight[g*WT_W +: WT_W];
      end else if (spend[g] && (credit_q != '0)) begin
        credit_q <= credit_q - 1'b1;
      end
    end

    assign has_credit[g] = (credit_q != '0);
    assign wt_nonzero[g] = (wt_q != '0);
  end
endmodule

// File: rtl/prio_wt_arbiter.sv
module prio_wt_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PRIO_W    = 3,
  parameter int WT_W      = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        req,
  input  logic [NUM_PORTS*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_PORTS*WT_W-1:0]   cfg_weight,
  input  logic                        accept,
  output logic [NUM_PORTS-1:0]        grant
);
  localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int LEVELS = 1 << PRIO_W;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_PORTS - 1);

  logic [NUM_PORTS-1:0]        grant_q;
  logic [NUM_PORTS*PRIO_W-1:0] prio_q;
  logic [IDX_W-1:0]            last_q [LEVELS];

  logic [PRIO_W-1:0]    top_lvl;
  logic [NUM_PORTS-1:0] at_lvl;
  logic [NUM_PORTS-1:0] has_credit;
  logic [NUM_PORTS-1:0] wt_nonzero;
  logic [NUM_PORTS-1:0] credit_cand;
  logic [NUM_PORTS-1:0] heavy_cand;
  logic [NUM_PORTS-1:0] pick_cand;
  logic [NUM_PORTS-1:0] pick_oh;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_found;
  logic                 busy;
  arb_act_e             act;
  logic                 do_reload;
  logic [NUM_PORTS-1:0] spend;

  pwa_level_find #(.NUM_PORTS(NUM_PORTS), .PRIO_W(PRIO_W)) u_level (
    .req     (req),
    .prio_q  (prio_q),
    .top_lvl (top_lvl),
    .at_lvl  (at_lvl)
  );

  assign busy        = |grant_q;
  assign credit_cand = at_lvl & has_credit;
  assign heavy_cand  = at_lvl & wt_nonzero;
  assign pick_cand   = (|credit_cand) ? credit_cand : at_lvl;

  pwa_rr_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pick (
    .cand     (pick_cand),
    .last     (last_q[top_lvl]),
    .found    (pick_found),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx)
  );

  always_comb begin
    act = ACT_IDLE;
    if (!busy) begin
      if (|credit_cand)     act = ACT_SPEND;
      else if (|heavy_cand) act = ACT_RELOAD;
      else if (|at_lvl)     act = ACT_FREE;
    end
  end

  assign do_reload = (act == ACT_RELOAD);
  assign spend     = (act == ACT_SPEND) ? pick_oh : '0;

  pwa_credit_bank #(.NUM_PORTS(NUM_PORTS), .WT_W(WT_W)) u_credit (
    .clk        (clk),
    .rst        (rst),
    .reload     (do_reload),
    .cfg_weight (cfg_weight),
    .spend      (spend),
    .has_credit (has_credit),
    .wt_nonzero (wt_nonzero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      prio_q  <= cfg_prio;
      for (int l = 0; l < LEVELS; l++) last_q[l] <= TOP_IDX;
    end else begin
      if (do_reload) prio_q <= cfg_prio;
      if (busy) begin
        if (accept) grant_q <= '0;
      end else if (((act == ACT_SPEND) || (act == ACT_FREE)) && pick_found) begin
        grant_q         <= pick_oh;
        last_q[top_lvl] <= pick_idx;
      end
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/pwa_checker.sv
module pwa_checker #(
  parameter int NUM_PORTS = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_PORTS-1:0] req,
  input logic                 accept,
  input logic [NUM_PORTS-1:0] grant
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == '0) |=> grant == '0);

  a_r1_to_requester: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |=> (grant == '0 || (grant & $past(req)) != '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !accept) |=> grant == $past(grant));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && accept) |=> grant == '0);

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> grant == '0);
endmodule

bind prio_wt_arbiter pwa_checker #(.NUM_PORTS(NUM_PORTS)) u_pwa_checker (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .accept (accept),
  .grant  (grant)
);

// File: tb/test_prio_wt_arbiter.sv
module test_prio_wt_arbiter;
  localparam int N  = 6;
  localparam int PW = 3;
  localparam int WW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req = '0;
  logic [N*PW-1:0] cfg_prio = '0;
  logic [N*WW-1:0] cfg_weight = '0;
  logic            accept = 1'b0;
  logic [N-1:0]    grant;

  int errors = 0;
  int checks = 0;
  int cnt [N];
  int seq [64];
  int gap [64];
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prio_wt_arbiter #(.NUM_PORTS(N), .PRIO_W(PW), .WT_W(WW)) i_prio_wt_arbiter (
    .clk(clk), .rst(rst), .req(req), .cfg_prio(cfg_prio),
    .cfg_weight(cfg_weight), .accept(accept), .grant(grant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_port(input int p, input int pr, input int wt, input bit rq);
    cfg_prio[p*PW +: PW]   = PW'(pr);
    cfg_weight[p*WW +: WW] = WW'(wt);
    req[p]                 = rq;
  endtask

  task automatic clear_all();
    for (int p = 0; p < N; p++) set_port(p, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int oh_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Collect n grants with accept high; records port order and cycle gaps.
  task automatic run_grants(input int n, input string tag);
    int prev_cyc;
    prev_cyc = -1;
    for (int p = 0; p < N; p++) cnt[p] = 0;
    accept = 1'b1;
    for (int k = 0; k < n; k++) begin
      int waited;
      waited = 0;
      @(negedge clk);
      while (grant == '0 && waited < 40) begin
        @(negedge clk);
        waited++;
      end
      if (grant == '0) begin
        chk({tag, " grant timeout"}, 0, 1);
        return;
      end
      if ($countones(grant) != 1) chk("R1 one-hot", $countones(grant), 1);
      if ((grant & req) == '0) chk("R1 grant to requester", int'(grant), int'(req));
      seq[k] = oh_idx(grant);
      gap[k] = (prev_cyc < 0) ? 0 : cyc - prev_cyc;
      prev_cyc = cyc;
      cnt[seq[k]]++;
    end
  endtask

  task automatic t_reset_idle();
    clear_all();
    accept = 1'b0;
    do_reset();
    @(negedge clk);
    chk("R9 grant zero after reset", int'(grant), 0);
    accept = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 no request gives zero grant", int'(grant), 0);
    end
  endtask

  task automatic t_share_4_6();
    clear_all();
    set_port(0, 1, 4, 1);
    set_port(1, 1, 6, 1);
    do_reset();
    run_grants(20, "R3 4/6");
    chk("R3 weight 4 share of 20", cnt[0], 8);
    chk("R3 weight 6 share of 20", cnt[1], 12);
  endtask

  task automatic t_round_robin();
    clear_all();
    set_port(1, 2, 2, 1);
    set_port(3, 2, 2, 1);
    set_port(5, 2, 2, 1);
    do_reset();
    run_grants(6, "R5 rr");
    chk("R5 order pos0", seq[0], 1);
    chk("R5 order pos1", seq[1], 3);
    chk("R5 order pos2", seq[2], 5);
    chk("R5 order pos3 wraps", seq[3], 1);
    chk("R5 order pos5", seq[5], 5);
  endtask

  task automatic t_priority();
    clear_all();
    set_port(4, 5, 1, 1);
    set_port(0, 2, 31, 1);
    do_reset();
    run_grants(6, "R2 prio");
    chk("R2 high level takes all", cnt[4], 6);
    chk("R2 low level starved", cnt[0], 0);
    req[4] = 1'b0;
    run_grants(3, "R2 low");
    chk("R2 low level served when alone", cnt[0], 3);
  endtask

  task automatic t_reload_gap();
    clear_all();
    set_port(2, 0, 1, 1);
    do_reset();
    run_grants(4, "R4 gap");
    chk("R4 weight-1 spacing", gap[1], 3);
    chk("R4 weight-1 spacing later", gap[3], 3);
    clear_all();
    set_port(2, 0, 2, 1);
    do_reset();
    run_grants(3, "R4 gap2");
    chk("R4 in-round spacing", gap[1], 2);
    chk("R4 spacing across reload", gap[2], 3);
  endtask

  task automatic t_weight_zero();
    clear_all();
    set_port(3, 4, 0, 1);
    set_port(1, 4, 3, 1);
    do_reset();
    run_grants(9, "R6 w0");
    chk("R6 zero weight not served", cnt[3], 0);
    chk("R6 weighted port served", cnt[1], 9);
    req[1] = 1'b0;
    run_grants(2, "R6 alone");
    chk("R6 zero weight served when alone", cnt[3], 2);
  endtask

  task automatic t_hold();
    int g0;
    int waited;
    clear_all();
    set_port(0, 1, 3, 1);
    set_port(2, 1, 3, 1);
    accept = 1'b0;
    do_reset();
    waited = 0;
    @(negedge clk);
    while (grant == '0 && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    g0 = int'(grant);
    chk("R7 first grant port 0", g0, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 grant held without accept", int'(grant), g0);
    end
    accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    chk("R7 grant zero after accept", int'(grant), 0);
    @(negedge clk);
    chk("R7 next grant one cycle later", int'(grant), 4);
  endtask

  task automatic t_cfg_change();
    clear_all();
    set_port(0, 1, 2, 1);
    set_port(1, 1, 2, 1);
    do_reset();
    run_grants(2, "R8 a");
    chk("R8 first grant", seq[0], 0);
    cfg_weight[0*WW +: WW] = 5'd5;
    run_grants(2, "R8 b");
    chk("R8 old round finishes p0", cnt[0], 1);
    chk("R8 old round finishes p1", cnt[1], 1);
    run_grants(7, "R8 c");
    chk("R8 new weight after reload p0", cnt[0], 5);
    chk("R8 new weight after reload p1", cnt[1], 2);
  endtask

  task automatic t_six_ports();
    clear_all();
    for (int p = 0; p < N; p++) set_port(p, 3, p + 1, 1);
    do_reset();
    run_grants(21, "R3 six");
    for (int p = 0; p < N; p++) chk($sformatf("R3 six-port share port %0d", p), cnt[p], p + 1);
  endtask

  initial begin
    t_reset_idle();
    t_share_4_6();
    t_round_robin();
    t_priority();
    t_reload_gap();
    t_weight_zero();
    t_hold();
    t_cfg_change();
    t_six_ports();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule